// File: doc/BRIEF.md
# Serial Flash Program and Erase Command Front-End

This block is the device-side command decoder of a serial NOR flash. It listens on a four-wire serial bus, with the clock idling low or high. It samples the chip-select, serial clock and serial data pins with the fast system clock. It accepts three commands. Two one-byte opcodes each erase the whole array. The third opcode starts a page program. The page program opcode is followed by a three-byte address and any number of data bytes. The data bytes are collected in an internal page buffer. The buffer pointer starts at the low address byte and wraps around inside the page, so that when the stream is longer than a page, only the most recent page's worth of bytes is kept.

The decision is taken when chip select goes high. An operation is launched only if the frame ends on a whole byte, the command is complete, and no earlier operation is still running. A launched operation holds the busy flag for a fixed, parameterised number of system cycles, which models the internal timer. During a program operation, the block walks the page buffer and writes each loaded byte to the array port. The written value is the old array byte ANDed with the new byte. A chip erase asserts a single clear-to-ones strobe in its final busy cycle. The array itself sits outside the block and is reached through a plain read/write port.

Top module: `spi_flash_pe_front`

## Requirements
- R1: While reset is held, `busy`, `arrWrEn` and `arrEraseAll` are all low.
- R2: A frame made of opcode 8'h60 or 8'hC7, followed by a whole-byte chip-select rise while idle, leaves every array byte reading 8'hFF when `busy` drops.
- R3: A frame made of opcode 8'h02, three address bytes (most significant byte and bit first) and one or more data bytes writes the k-th data byte to page `addr[18:8]` at offset `(addr[7:0]+k) mod 256`. Address bits 23 to 19 are ignored.
- R4: When more than 256 data bytes arrive in one program frame, the array ends up holding only the last 256 of them, each at its wrapped offset.
- R5: Programming only clears bits: the stored byte becomes the old byte AND the data byte.
- R6: If chip select rises after a partial byte (bit count not a multiple of 8), nothing is started and the array is unchanged.
- R7: A program frame that ends before its first data byte is complete starts nothing.
- R8: Any command whose opcode completes while `busy` is high is ignored. The running operation keeps its length, and the array is not touched by the ignored command.
- R9: `busy` rises only after a qualifying chip-select rise. It stays high for exactly PROG_CYCLES system cycles for a program and ERASE_CYCLES cycles for an erase.
- R10: Frames behave the same whether the serial clock idles low (mode 0) or high (mode 3). Data is sampled on rising serial clock edges.
- R11: Any other opcode starts nothing, and its trailing bytes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock (at most one quarter of the clk rate) |
| si | input | 1 | Serial data in, most significant bit first |
| busy | output | 1 | High while a program or erase is running |
| arrAddr | output | 19 | Array byte address: page from the command, offset from the buffer walk |
| arrRdData | input | 8 | Array read data for `arrAddr`, valid in the same cycle |
| arrWrEn | output | 1 | Array byte write strobe |
| arrWrData | output | 8 | Array write data (old byte ANDed with the buffered byte) |
| arrEraseAll | output | 1 | Single-cycle strobe that sets every array byte to 8'hFF |

## Verification
A wrong bit counter or phase state shows up at the ports as a busy pulse that appears or goes missing right after chip select rises, typically within four system cycles. A wrong buffer pointer or valid mask shows up only after the program finishes, as bytes at shifted or unwritten offsets in the array. For that reason every program case is compared byte by byte across the whole page against a model. The busy width is counted exactly, so a timer that is off by one, or a restart by an ignored command, appears as a wrong pulse length.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  localparam logic [7:0] OP_ERASE_A = 8'h60;
  localparam logic [7:0] OP_ERASE_B = 8'hC7;
  localparam logic [7:0] OP_PROGRAM = 8'h02;

  // Frame decoding phase
  typedef enum logic [2:0] {
    PH_OP,
    PH_ADDR,
    PH_DATA,
    PH_ERASE,
    PH_IGN
  } phase_t;

  // Self-timed job
  typedef enum logic [1:0] {
    JOB_IDLE,
    JOB_PROG,
    JOB_ERASE
  } job_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic shiftBit;   // take one serial bit
    logic addrByte;   // append finished byte to address
    logic ptrLoad;    // last address byte: load pointer, clear valid mask
    logic dataStore;  // store finished byte into page buffer
    logic walkWrite;  // program walk: write slot to array if loaded
  } strobe_t;

endpackage

// File: rtl/flash_fe_ctrl.sv
module flash_fe_ctrl
  import flash_fe_pkg::*;
#(
  parameter int PAGE_BYTES   = 256,
  parameter int PROG_CYCLES  = 300,
  parameter int ERASE_CYCLES = 400,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          csN,
  input  logic                          sck,
  input  logic                          si,
  input  logic [7:0]                    rxByte,
  output strobe_t                       strb,
  output logic                          siBit,
  output logic [$clog2(PAGE_BYTES)-1:0] walkSlot,
  output logic                          busy,
  output logic                          eraseAll
);

  localparam int PTR_W   = $clog2(PAGE_BYTES);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] WALK_END   = CNT_W'(PAGE_BYTES);
  localparam int PIPE_W  = SYNC_STAGES + 1;

  // Pin synchronisers; the extra stage on cs and sck gives edge detection
  logic [PIPE_W-1:0]      csPipe;
  logic [PIPE_W-1:0]      sckPipe;
  logic [SYNC_STAGES-1:0] siPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe  <= '1;
      sckPipe <= '0;
      siPipe  <= '0;
    end else begin
      csPipe  <= {csPipe[PIPE_W-2:0], csN};
      sckPipe <= {sckPipe[PIPE_W-2:0], sck};
      siPipe  <= {siPipe[SYNC_STAGES-2:0], si};
    end
  end

  logic csHigh, csRise, sckRise;
  assign csHigh  = csPipe[SYNC_STAGES-1];
  assign csRise  = csPipe[SYNC_STAGES-1] & ~csPipe[SYNC_STAGES];
  assign sckRise = sckPipe[SYNC_STAGES-1] & ~sckPipe[SYNC_STAGES] & ~csHigh;
  assign siBit   = siPipe[SYNC_STAGES-1];

  // Frame state
  logic [2:0] bitCnt;
  logic [1:0] addrCnt;
  logic       dataSeen;
  phase_t     phase;
  logic       byteDone;

  assign byteDone = sckRise && (bitCnt == 3'd7);

  // Job state
  job_t             job;
  logic [CNT_W-1:0] timer;
  logic             startProg, startErase;

  assign busy       = (job != JOB_IDLE);
  assign startProg  = csRise && !busy && (bitCnt == 3'd0) && (phase == PH_DATA) && dataSeen;
  assign startErase = csRise && !busy && (bitCnt == 3'd0) && (phase == PH_ERASE);

  always_comb begin
    strb.shiftBit  = sckRise;
    strb.addrByte  = byteDone && (phase == PH_ADDR);
    strb.ptrLoad   = byteDone && (phase == PH_ADDR) && (addrCnt == 2'd2);
    strb.dataStore = byteDone && (phase == PH_DATA);
    strb.walkWrite = (job == JOB_PROG) && (timer < WALK_END);
  end

  assign walkSlot = timer[PTR_W-1:0];
  assign eraseAll = (job == JOB_ERASE) && (timer == ERASE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      addrCnt  <= '0;
      dataSeen <= 1'b0;
      phase    <= PH_OP;
    end else if (csHigh) begin
      bitCnt   <= '0;
      addrCnt  <= '0;
      dataSeen <= 1'b0;
      phase    <= PH_OP;
    end else if (sckRise) begin
      bitCnt <= bitCnt + 3'd1;
      if (bitCnt == 3'd7) begin
        unique case (phase)
          PH_OP: begin
            if (busy) begin
              phase <= PH_IGN;
            end else if (rxByte == OP_ERASE_A || rxByte == OP_ERASE_B) begin
              phase <= PH_ERASE;
            end else if (rxByte == OP_PROGRAM) begin
              phase <= PH_ADDR;
            end else begin
              phase <= PH_IGN;
            end
          end
          PH_ADDR: begin
            addrCnt <= addrCnt + 2'd1;
            if (addrCnt == 2'd2) phase <= PH_DATA;
          end
          PH_DATA:  dataSeen <= 1'b1;
          PH_ERASE: phase <= PH_ERASE;
          default:  phase <= PH_IGN;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      job   <= JOB_IDLE;
      timer <= '0;
    end else begin
      unique case (job)
        JOB_IDLE: begin
          timer <= '0;
          if (startProg)       job <= JOB_PROG;
          else if (startErase) job <= JOB_ERASE;
        end
        JOB_PROG: begin
          if (timer == PROG_LAST) begin
            job   <= JOB_IDLE;
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        JOB_ERASE: begin
          if (timer == ERASE_LAST) begin
            job   <= JOB_IDLE;
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: job <= JOB_IDLE;
      endcase
    end
  end

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise));

  // R6
  aligned_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(bitCnt) == 3'd0));

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(timer) == PROG_LAST || $past(timer) == ERASE_LAST));

  // R8
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && byteDone && phase == PH_OP) |=> (phase == PH_IGN));

  // R2
  erase_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseAll |=> !busy);

endmodule

// File: rtl/flash_fe_dp.sv
module flash_fe_dp
  import flash_fe_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int ARRAY_AW   = 19
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic                          siBit,
  input  logic [$clog2(PAGE_BYTES)-1:0] walkSlot,
  output logic [7:0]                    rxByte,
  output logic [ARRAY_AW-1:0]           arrAddr,
  input  logic [7:0]                    arrRdData,
  output logic                          arrWrEn,
  output logic [7:0]                    arrWrData
);

  localparam int PTR_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ARRAY_AW - PTR_W;

  logic [7:0]            shiftReg;
  logic [23:0]           addrReg;
  logic [PTR_W-1:0]      ptr;
  logic [PAGE_BYTES-1:0] validBits;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_W-1:0]     pageSel;

  assign rxByte  = {shiftReg[6:0], siBit};
  assign pageSel = addrReg[ARRAY_AW-1:PTR_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      addrReg   <= '0;
      ptr       <= '0;
      validBits <= '0;
    end else begin
      if (strb.shiftBit) shiftReg <= rxByte;
      if (strb.addrByte) addrReg  <= {addrReg[15:0], rxByte};
      if (strb.ptrLoad) begin
        ptr       <= rxByte[PTR_W-1:0];
        validBits <= '0;
      end else if (strb.dataStore) begin
        validBits[ptr] <= 1'b1;
        ptr            <= ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.dataStore) pageBuf[ptr] <= rxByte;
  end

  assign arrAddr   = {pageSel, walkSlot};
  assign arrWrEn   = strb.walkWrite & validBits[walkSlot];
  assign arrWrData = pageBuf[walkSlot] & arrRdData;

  // R5
  clear_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> ((arrWrData & ~arrRdData) == 8'h00));

  // R3
  store_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataStore |-> !strb.walkWrite);

endmodule

// File: rtl/spi_flash_pe_front.sv
module spi_flash_pe_front
  import flash_fe_pkg::*;
#(
  parameter int PAGE_BYTES   = 256,
  parameter int ARRAY_AW     = 19,
  parameter int PROG_CYCLES  = 300,
  parameter int ERASE_CYCLES = 400
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sck,
  input  logic                si,
  output logic                busy,
  output logic [ARRAY_AW-1:0] arrAddr,
  input  logic [7:0]          arrRdData,
  output logic                arrWrEn,
  output logic [7:0]          arrWrData,
  output logic                arrEraseAll
);

  localparam int PTR_W = $clog2(PAGE_BYTES);

  strobe_t          strb;
  logic             siBit;
  logic [7:0]       rxByte;
  logic [PTR_W-1:0] walkSlot;

  flash_fe_ctrl #(
    .PAGE_BYTES  (PAGE_BYTES),
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES),
    .SYNC_STAGES (2)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .sck     (sck),
    .si      (si),
    .rxByte  (rxByte),
    .strb    (strb),
    .siBit   (siBit),
    .walkSlot(walkSlot),
    .busy    (busy),
    .eraseAll(arrEraseAll)
  );

  flash_fe_dp #(
    .PAGE_BYTES(PAGE_BYTES),
    .ARRAY_AW  (ARRAY_AW)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .siBit    (siBit),
    .walkSlot (walkSlot),
    .rxByte   (rxByte),
    .arrAddr  (arrAddr),
    .arrRdData(arrRdData),
    .arrWrEn  (arrWrEn),
    .arrWrData(arrWrData)
  );

  // R1
  quiet_reset_chk: assert property (@(posedge clk)
    !rstN |-> (!busy && !arrWrEn && !arrEraseAll));

endmodule

// File: tb/spi_flash_pe_front_tb_top.sv
`timescale 1ns/1ps
module spi_flash_pe_front_tb_top;

  localparam int PROG_CYC  = 300;
  localparam int ERASE_CYC = 400;
  localparam int HALF      = 20;   // serial half period in ns (4 clk)

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sck = 1'b0;
  logic        si = 1'b0;
  logic        busy;
  logic [18:0] arrAddr;
  logic [7:0]  arrRdData = 8'hFF;
  logic        arrWrEn;
  logic [7:0]  arrWrData;
  logic        arrEraseAll;

  always #2.5 clk = ~clk;

  spi_flash_pe_front #(
    .PAGE_BYTES(256), .ARRAY_AW(19), .PROG_CYCLES(PROG_CYC), .ERASE_CYCLES(ERASE_CYC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .busy(busy),
    .arrAddr(arrAddr), .arrRdData(arrRdData), .arrWrEn(arrWrEn),
    .arrWrData(arrWrData), .arrEraseAll(arrEraseAll)
  );

  // Behavioural array and reference model (absent key = 8'hFF)
  logic [7:0] mem [int];
  logic [7:0] expm [int];
  logic [7:0] dq [$];

  function automatic logic [7:0] memRd(int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction
  function automatic logic [7:0] expRd(int a);
    return expm.exists(a) ? expm[a] : 8'hFF;
  endfunction

  always @(negedge clk) arrRdData = memRd(int'(arrAddr));
  always @(posedge clk) begin
    if (arrWrEn) mem[int'(arrAddr)] = arrWrData;
    if (arrEraseAll) mem.delete();
  end

  // Busy pulse monitor
  int riseCnt = 0, lastWidth = 0, curW = 0;
  logic prevBusy = 1'b0;
  always @(negedge clk) begin
    if (busy) curW++;
    else if (curW != 0) begin lastWidth = curW; curW = 0; end
    if (busy && !prevBusy) riseCnt++;
    prevBusy = busy;
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic spiStart(input bit m3);
    sck = m3; #(HALF); csN = 1'b0; #(HALF);
  endtask
  task automatic spiBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; si = b[i]; #(HALF); sck = 1'b1; #(HALF);
    end
  endtask
  task automatic spiByte(input logic [7:0] b);
    spiBits(b, 8);
  endtask
  task automatic spiEnd(input bit m3);
    if (!m3) sck = 1'b0;
    #(HALF); csN = 1'b1; #(HALF);
  endtask

  task automatic waitIdle();
    repeat (10) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic sendProgram(input bit m3, input logic [4:0] hi, input int page, input int off);
    logic [23:0] a;
    a = {hi, 11'(page), 8'(off)};
    spiStart(m3);
    spiByte(8'h02);
    spiByte(a[23:16]); spiByte(a[15:8]); spiByte(a[7:0]);
    foreach (dq[k]) spiByte(dq[k]);
    spiEnd(m3);
  endtask

  task automatic modelProgram(input int page, input int off);
    int n, s, a;
    n = dq.size();
    s = (n > 256) ? n - 256 : 0;
    for (int k = s; k < n; k++) begin
      a = page * 256 + ((off + k) % 256);
      expm[a] = expRd(a) & dq[k];
    end
  endtask

  task automatic cmpPage(input int page, input string req);
    int bad, fa, fe;
    bad = 0; fa = 0; fe = 0;
    for (int o = 0; o < 256; o++) begin
      if (memRd(page * 256 + o) !== expRd(page * 256 + o)) begin
        if (bad == 0) begin fa = memRd(page * 256 + o); fe = expRd(page * 256 + o); end
        bad++;
      end
    end
    chk(bad == 0, req, $sformatf("page %0h contents", page), fa, fe);
  endtask

  task automatic fillRand(input int n);
    dq.delete();
    for (int k = 0; k < n; k++) dq.push_back(8'($urandom));
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base, seedv;
    seedv = $urandom(32'd5417);
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0 && arrWrEn == 1'b0 && arrEraseAll == 1'b0, "R1", "outputs in reset",
        {busy, arrWrEn, arrEraseAll}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R9: basic program, mode 0, junk upper address bits
    dq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    base = riseCnt;
    sendProgram(1'b0, 5'h1F, 11'h123, 8'h10);
    modelProgram(11'h123, 8'h10);
    waitIdle();
    cmpPage(11'h123, "R3");
    chk(riseCnt == base + 1, "R9", "program busy pulses", riseCnt - base, 1);
    chk(lastWidth == PROG_CYC, "R9", "program busy width", lastWidth, PROG_CYC);

    // R3 R10: wrap inside page, mode 3
    dq = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    sendProgram(1'b1, 5'h00, 11'h7FF, 8'hFE);
    modelProgram(11'h7FF, 8'hFE);
    waitIdle();
    cmpPage(11'h7FF, "R3 R10");
    chk(memRd(11'h7FF * 256 + 1) == 8'hD4, "R3", "wrapped offset 01", memRd(11'h7FF * 256 + 1), 8'hD4);

    // R5: AND with existing contents
    dq = '{8'hF0, 8'h0F, 8'hFF, 8'h00, 8'h5A};
    sendProgram(1'b0, 5'h00, 11'h123, 8'h10);
    modelProgram(11'h123, 8'h10);
    waitIdle();
    cmpPage(11'h123, "R5");
    chk(memRd(11'h123 * 256 + 16'h10) == 8'h10, "R5", "and of 11 and F0",
        memRd(11'h123 * 256 + 16'h10), 8'h10);

    // R4: overrun, 300 bytes
    fillRand(300);
    sendProgram(1'b0, 5'h00, 11'h040, 8'h05);
    modelProgram(11'h040, 8'h05);
    waitIdle();
    cmpPage(11'h040, "R4");
    chk(memRd(11'h040 * 256 + 5) == dq[256], "R4", "offset 05 holds byte 256",
        memRd(11'h040 * 256 + 5), dq[256]);

    // R6: partial final byte on program and erase
    base = riseCnt;
    spiStart(1'b0); spiByte(8'h02); spiByte(8'h00); spiByte(8'h12); spiByte(8'h30);
    spiByte(8'h00); spiByte(8'h00); spiBits(8'h00, 3); spiEnd(1'b0);
    repeat (20) @(negedge clk);
    spiStart(1'b1); spiByte(8'hC7); spiBits(8'hFF, 5); spiEnd(1'b1);
    repeat (20) @(negedge clk);
    spiStart(1'b0); spiBits(8'h60, 6); spiEnd(1'b0);
    repeat (20) @(negedge clk);
    chk(riseCnt == base, "R6", "busy after misaligned frames", riseCnt - base, 0);
    cmpPage(11'h012, "R6");
    cmpPage(11'h040, "R6");

    // R7: program with no complete data byte
    spiStart(1'b0); spiByte(8'h02); spiByte(8'h00); spiByte(8'h40); spiByte(8'h00); spiEnd(1'b0);
    repeat (20) @(negedge clk);
    spiStart(1'b1); spiByte(8'h02); spiByte(8'h00); spiByte(8'h40); spiEnd(1'b1);
    repeat (20) @(negedge clk);
    chk(riseCnt == base, "R7", "busy without data", riseCnt - base, 0);

    // R11: unknown opcodes
    spiStart(1'b0); spiByte(8'h9F); spiByte(8'h00); spiByte(8'h40); spiByte(8'h00); spiByte(8'h00); spiEnd(1'b0);
    repeat (20) @(negedge clk);
    spiStart(1'b0); spiByte(8'hAB); spiEnd(1'b0);
    repeat (20) @(negedge clk);
    chk(riseCnt == base, "R11", "busy after unknown opcodes", riseCnt - base, 0);
    cmpPage(11'h040, "R11");

    // R8: erase opcode while a program runs is ignored
    dq = '{8'h77, 8'h66, 8'h55};
    base = riseCnt;
    sendProgram(1'b0, 5'h00, 11'h200, 8'h00);
    modelProgram(11'h200, 8'h00);
    while (!busy) @(negedge clk);
    spiStart(1'b0); spiByte(8'hC7); spiEnd(1'b0);
    waitIdle();
    chk(riseCnt == base + 1, "R8", "busy pulses with ignored erase", riseCnt - base, 1);
    chk(lastWidth == PROG_CYC, "R8", "busy width with ignored erase", lastWidth, PROG_CYC);
    cmpPage(11'h200, "R8");
    cmpPage(11'h123, "R8");

    // R2 R9: erase 60h mode 0
    base = riseCnt;
    spiStart(1'b0); spiByte(8'h60); spiEnd(1'b0);
    expm.delete();
    waitIdle();
    chk(mem.size() == 0, "R2", "non-erased bytes after 60h", mem.size(), 0);
    chk(lastWidth == ERASE_CYC, "R9", "erase busy width", lastWidth, ERASE_CYC);
    chk(riseCnt == base + 1, "R2", "erase busy pulses", riseCnt - base, 1);

    // Random program frames
    for (int it = 0; it < 5; it++) begin
      int pg, of, n;
      bit m3;
      pg = int'($urandom % 2048);
      of = int'($urandom % 256);
      n  = 1 + int'($urandom % 280);
      m3 = 1'($urandom);
      fillRand(n);
      sendProgram(m3, 5'($urandom), pg, of);
      modelProgram(pg, of);
      waitIdle();
      cmpPage(pg, (n > 256) ? "R4" : "R3");
      chk(lastWidth == PROG_CYC, "R9", "random program busy width", lastWidth, PROG_CYC);
    end

    // R2 R10: erase C7h mode 3 after programming
    spiStart(1'b1); spiByte(8'hC7); spiEnd(1'b1);
    expm.delete();
    waitIdle();
    chk(mem.size() == 0, "R2 R10", "non-erased bytes after C7h", mem.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule